// File: doc/BRIEF.md
# Debug Unit Select Register

This block is the data register that sits behind a JTAG TAP while the debug instruction is loaded. The TAP brackets each frame with three strobes: capture, shift and update. During each frame the register takes bits from `tdi` on rising `tck` edges. The first bit is a flag. When the flag is 1, the frame is a request to choose which debug sub-unit is active: the system bus unit, CPU0 or CPU1. When the flag is 0, the frame belongs to the sub-unit that is already active, and this register stays silent.

A select request carries a 4-bit unit number and a 32-bit CRC. The register checks the CRC over the flag and the unit number. It then answers on `tdo` with a 4-bit status word, followed by a CRC of its own that covers that status word. On the update strobe the one-hot `unit_sel` output takes the new choice, but only when three conditions hold: the request was complete, the CRC matched and the unit number exists. A bit counter, restarted by the capture strobe, steps through the phases of the frame.

Top module: `dbg_module_select`

## Requirements
- R1: After reset, `unit_sel` is all zeros and `tdo` is 0.
- R2: A frame whose first bit is 0 leaves `unit_sel` unchanged on update. `tdo` stays 0 for the whole of that frame.
- R3: After the flag, the 4-bit unit number arrives most significant bit first. On a valid update, number 0 sets `unit_sel` bit 0 (bus), 1 sets bit 1 (CPU0) and 2 sets bit 2 (CPU1). `unit_sel` is never more than one-hot.
- R4: The received CRC is the bit-serial CRC-32 with polynomial 0x04C11DB7. It is preset to all ones at capture and runs over the flag bit and the 4 unit-number bits. The 32 CRC bits follow the unit number, most significant bit first. On a mismatch, status bit 3 is set and update leaves `unit_sel` unchanged.
- R5: A unit number of 3 or more sets status bit 2, and update leaves `unit_sel` unchanged.
- R6: Number the shift edges from 0 after capture. After edges 37 to 40, `tdo` shows status bits 3, 2, 1 and 0, one bit per edge. Status bits 1 and 0 are always 0.
- R7: After edges 41 to 72, `tdo` shows a CRC-32 of the four status bits, most significant bit first. This CRC uses the same polynomial and is preset to all ones. Feeding all 36 reply bits through that CRC leaves a residue of zero. After edge 73 and later, `tdo` is 0.
- R8: `unit_sel` changes only on the update strobe, and only after at least 37 shift edges have completed the received CRC. A shorter frame, or a complete frame with no update strobe, keeps the previous selection.
- R9: `tdo` is 0 whenever the shift strobe is low.
- R10: The capture strobe restarts the frame. A frame abandoned part-way through has no effect on the frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cap_dr | input | 1 | TAP is in Capture-DR; restarts the frame |
| shift_dr | input | 1 | TAP is in Shift-DR; one frame bit per edge |
| upd_dr | input | 1 | TAP is in Update-DR; commits a valid selection |
| tdi | input | 1 | Serial frame input |
| tdo | output | 1 | Serial reply: status, then reply CRC |
| unit_sel | output | 3 | One-hot active sub-unit (bit 0 bus, 1 CPU0, 2 CPU1) |

## Verification
Three kinds of internal fault show up at the ports in different ways. A phase counter that is off by one shifts the whole reply by one bit, so the first status bit already looks wrong after edge 37. A CRC tap that is wrong on the receive side makes every good frame report a mismatch and refuse the update. A wrong tap on the transmit side spoils the 32-bit reply, and the zero-residue check on the host side catches it at the end of that same frame. A fault in the commit logic only appears on the next `unit_sel` sample after an update strobe, so every frame ends with an update and a check of `unit_sel`.

// File: rtl/dbg_sel_pkg.sv
`timescale 1ns/1ps
package dbg_sel_pkg;
   // reply status word, sent from the top bit downwards
   typedef struct packed {
      logic       crc_err;   // bit 3: received CRC mismatched
      logic       bad_unit;  // bit 2: unit number does not exist
      logic [1:0] rsvd;      // bits 1:0: always zero
   } sel_status_t;

   localparam int unsigned STAT_W = $bits(sel_status_t);
   localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/dbg_crc_ser.sv
`timescale 1ns/1ps
// Bit-serial CRC with preset, step and drain (shift-out) modes.
module dbg_crc_ser #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         init,
   input  logic         step,
   input  logic         drain,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic         fb;
   logic [W-1:0] nxt;

   assign fb = din ^ crc[W-1];

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         if (POLY[0]) begin : g_tap
            assign nxt[0] = fb;
         end else begin : g_zero
            assign nxt[0] = 1'b0;
         end
      end else if (POLY[i]) begin : g_tap
         assign nxt[i] = crc[i-1] ^ fb;
      end else begin : g_pass
         assign nxt[i] = crc[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || init) crc <= '1;
      else if (step)   crc <= nxt;
      else if (drain)  crc <= {crc[W-2:0], 1'b0};
   end

   a_r4_preset_ones: assert property (@(posedge clk) disable iff (rst)
      init |=> (crc == '1));
   a_r7_drain_moves_up: assert property (@(posedge clk) disable iff (rst)
      (drain && !init && !step) |=> (crc[W-1:1] == $past(crc[W-2:0])));
endmodule

// File: rtl/dbg_sel_dec.sv
`timescale 1ns/1ps
// Unit number to one-hot select decode.
module dbg_sel_dec #(
   parameter int unsigned ID_W    = 4,
   parameter int unsigned N_UNITS = 3
) (
   input  logic [ID_W-1:0]    id,
   output logic               valid,
   output logic [N_UNITS-1:0] onehot
);
   for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
      assign onehot[i] = (id == ID_W'(i));
   end
   assign valid = |onehot;

   always_comb begin
      if (!$isunknown(id)) begin
         a_r5_valid_range: assert (valid == (int'(id) < int'(N_UNITS)));
      end
   end
endmodule

// File: rtl/dbg_module_select.sv
`timescale 1ns/1ps
module dbg_module_select
   import dbg_sel_pkg::*;
#(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned N_UNITS  = 3,
   parameter int unsigned CRC_W    = 32,
   parameter logic [CRC_W-1:0] CRC_POLY = CRC_W'(CRC32_POLY)
) (
   input  logic               tck,
   input  logic               rst,
   input  logic               cap_dr,
   input  logic               shift_dr,
   input  logic               upd_dr,
   input  logic               tdi,
   output logic               tdo,
   output logic [N_UNITS-1:0] unit_sel
);
   // frame layout in shift edges after capture
   localparam int unsigned P_ID  = 1;
   localparam int unsigned P_RC  = P_ID + ID_W;
   localparam int unsigned P_ST  = P_RC + CRC_W;
   localparam int unsigned P_TC  = P_ST + STAT_W;
   localparam int unsigned P_END = P_TC + CRC_W;
   localparam int unsigned CNT_W = $clog2(P_END + 1);
   localparam logic [CNT_W-1:0] C_ID  = CNT_W'(P_ID);
   localparam logic [CNT_W-1:0] C_RC  = CNT_W'(P_RC);
   localparam logic [CNT_W-1:0] C_ST  = CNT_W'(P_ST);
   localparam logic [CNT_W-1:0] C_TC  = CNT_W'(P_TC);
   localparam logic [CNT_W-1:0] C_END = CNT_W'(P_END);

   if (ID_W < 1 || N_UNITS < 1 || N_UNITS > (1 << ID_W)) begin : g_bad_units
      $error("unit count does not fit the unit number width");
   end
   if (CRC_W < 8) begin : g_bad_crc
      $error("CRC width too small");
   end

   logic [CNT_W-1:0]   cnt;
   logic               flag_q;
   logic [ID_W-1:0]    id_q;
   logic               mism_q;
   logic [STAT_W-1:0]  st_sr;
   logic               tdo_q;
   logic [N_UNITS-1:0] sel_q;
   logic [CRC_W-1:0]   rx_crc, tx_crc;
   logic               id_ok;
   logic [N_UNITS-1:0] dec_oh;
   sel_status_t        stat_c;
   logic               st_bit;
   logic               in_flag, in_id, in_rc, in_st, in_tc;

   assign in_flag = (cnt == '0);
   assign in_id   = (cnt >= C_ID) && (cnt < C_RC);
   assign in_rc   = (cnt >= C_RC) && (cnt < C_ST);
   assign in_st   = (cnt >= C_ST) && (cnt < C_TC);
   assign in_tc   = (cnt >= C_TC) && (cnt < C_END);

   assign stat_c = '{crc_err: mism_q, bad_unit: ~id_ok, rsvd: 2'b00};
   assign st_bit = (cnt == C_ST) ? stat_c[STAT_W-1] : st_sr[STAT_W-1];

   dbg_sel_dec #(.ID_W(ID_W), .N_UNITS(N_UNITS)) u_dec (
      .id(id_q), .valid(id_ok), .onehot(dec_oh));

   // receive side: accumulate over flag+id, then drain to compare
   dbg_crc_ser #(.W(CRC_W), .POLY(CRC_POLY)) u_rx_crc (
      .clk(tck), .rst(rst), .init(cap_dr),
      .step(shift_dr && !cap_dr && (in_flag || in_id)),
      .drain(shift_dr && !cap_dr && in_rc),
      .din(tdi), .crc(rx_crc));

   // transmit side: accumulate over status, then drain onto tdo
   dbg_crc_ser #(.W(CRC_W), .POLY(CRC_POLY)) u_tx_crc (
      .clk(tck), .rst(rst), .init(cap_dr),
      .step(shift_dr && !cap_dr && flag_q && in_st),
      .drain(shift_dr && !cap_dr && flag_q && in_tc),
      .din(st_bit), .crc(tx_crc));

   always_ff @(posedge tck) begin
      if (rst) begin
         cnt    <= '0;
         flag_q <= 1'b0;
         id_q   <= '0;
         mism_q <= 1'b0;
         st_sr  <= '0;
         tdo_q  <= 1'b0;
         sel_q  <= '0;
      end else begin
         if (cap_dr) begin
            cnt    <= '0;
            flag_q <= 1'b0;
            id_q   <= '0;
            mism_q <= 1'b0;
            tdo_q  <= 1'b0;
         end else if (shift_dr) begin
            if (cnt != C_END) cnt <= cnt + 1'b1;
            if (in_flag) flag_q <= tdi;
            if (in_id) id_q <= ID_W'({id_q, tdi});
            if (in_rc && (tdi != rx_crc[CRC_W-1])) mism_q <= 1'b1;
            tdo_q <= 1'b0;
            if (flag_q && in_st) begin
               tdo_q <= st_bit;
               st_sr <= (cnt == C_ST) ? {stat_c[STAT_W-2:0], 1'b0}
                                      : {st_sr[STAT_W-2:0], 1'b0};
            end
            if (flag_q && in_tc) tdo_q <= tx_crc[CRC_W-1];
         end else if (upd_dr && flag_q && (cnt >= C_ST) && !mism_q && id_ok) begin
            sel_q <= dec_oh;
         end
      end
   end

   assign tdo      = shift_dr & tdo_q;
   assign unit_sel = sel_q;

   a_r3_sel_onehot: assert property (@(posedge tck) disable iff (rst)
      $onehot0(unit_sel));
   a_r8_sel_only_on_update: assert property (@(posedge tck) disable iff (rst)
      !upd_dr |=> $stable(unit_sel));
   a_r5_bad_unit_keeps: assert property (@(posedge tck) disable iff (rst)
      (upd_dr && !id_ok) |=> $stable(unit_sel));
   a_r4_mismatch_keeps: assert property (@(posedge tck) disable iff (rst)
      (upd_dr && mism_q) |=> $stable(unit_sel));
   a_r10_capture_restarts: assert property (@(posedge tck) disable iff (rst)
      cap_dr |=> (cnt == '0));
   a_r2_data_frame_quiet: assert property (@(posedge tck) disable iff (rst)
      !flag_q |-> !tdo);
endmodule

// File: tb/dbg_module_select_test.sv
`timescale 1ns/1ps
module dbg_module_select_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic       tdo;
   logic [2:0] sel;

   int n_chk = 0;
   int n_fail = 0;
   logic [2:0] exp_sel = 3'b000;

   int    exp_q[$];
   string tag_q[$];
   bit    obs_q[$];

   always #2.5 clk = ~clk;

   dbg_module_select uut (
      .tck(clk), .rst(rst), .cap_dr(cap), .shift_dr(shf), .upd_dr(upd),
      .tdi(tdi), .tdo(tdo), .unit_sel(sel));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic d);
      logic fb;
      fb = d ^ c[31];
      crc_step = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
   endfunction

   // monitor: compare tdo after every shift edge with the scoreboard
   always @(posedge clk) begin
      if (shf) begin
         #1;
         obs_q.push_back(tdo);
         if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(tdo === 1'(e), t, "tdo reply bit", int'(tdo), e);
         end
      end
   end

   task automatic run_frame(input bit flg, input logic [3:0] id, input bit bad,
                            input int nbits, input bit do_upd, input string req);
      logic [31:0] c, tc, res;
      logic [36:0] fr;
      logic [3:0]  st;
      c = '1;
      c = crc_step(c, flg);
      for (int i = 3; i >= 0; i--) c = crc_step(c, id[i]);
      if (bad) c[0] = ~c[0];
      fr = {flg, id, c};
      st = {bad, (id >= 4'd3), 2'b00};
      tc = '1;
      for (int i = 3; i >= 0; i--) tc = crc_step(tc, st[i]);
      obs_q.delete();
      @(negedge clk) cap = 1'b1;
      @(negedge clk) cap = 1'b0;
      shf = 1'b1;
      for (int n = 0; n < nbits; n++) begin
         tdi = (n < 37) ? fr[36-n] : 1'b0;
         if (flg && n >= 37 && n < 41) begin
            exp_q.push_back(int'(st[3-(n-37)])); tag_q.push_back("R6");
         end else if (flg && n >= 41 && n < 73) begin
            exp_q.push_back(int'(tc[31-(n-41)])); tag_q.push_back("R7");
         end else begin
            exp_q.push_back(0); tag_q.push_back(flg ? "R6" : "R2");
         end
         @(negedge clk);
      end
      shf = 1'b0;
      #1;
      check(tdo == 1'b0, "R9", "tdo with shift low", int'(tdo), 0);
      if (flg && nbits >= 73 && obs_q.size() >= 73) begin
         res = '1;
         for (int n = 37; n < 73; n++) res = crc_step(res, obs_q[n]);
         check(res == 32'h0, "R7", "reply CRC residue", int'(res), 0);
      end
      if (do_upd) begin
         @(negedge clk) upd = 1'b1;
         @(negedge clk) upd = 1'b0;
         if (flg && nbits >= 37 && !bad && id < 4'd3) exp_sel = 3'b001 << id;
      end
      @(negedge clk);
      check(sel == exp_sel, req, "unit_sel after frame", int'(sel), int'(exp_sel));
   endtask

   initial begin
      #(5.0 * 150000);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(sel == 3'b000, "R1", "unit_sel after reset", int'(sel), 0);
      check(tdo == 1'b0, "R1", "tdo after reset", int'(tdo), 0);

      run_frame(1'b1, 4'd1, 1'b0, 75, 1'b1, "R3");   // CPU0
      run_frame(1'b1, 4'd2, 1'b0, 75, 1'b1, "R3");   // CPU1
      run_frame(1'b1, 4'd0, 1'b0, 75, 1'b1, "R3");   // bus
      run_frame(1'b1, 4'd1, 1'b1, 75, 1'b1, "R4");   // corrupted CRC
      run_frame(1'b1, 4'd5, 1'b0, 75, 1'b1, "R5");   // missing unit
      run_frame(1'b1, 4'd15, 1'b0, 73, 1'b1, "R5");
      run_frame(1'b1, 4'd3, 1'b0, 75, 1'b1, "R5");   // first number past range
      run_frame(1'b0, 4'd2, 1'b0, 75, 1'b1, "R2");   // data frame
      run_frame(1'b1, 4'd2, 1'b0, 30, 1'b1, "R8");   // CRC cut short
      run_frame(1'b1, 4'd2, 1'b0, 36, 1'b1, "R8");   // one bit short
      run_frame(1'b1, 4'd2, 1'b0, 75, 1'b0, "R8");   // no update strobe
      run_frame(1'b1, 4'd2, 1'b0, 37, 1'b1, "R8");   // exactly complete
      run_frame(1'b1, 4'd0, 1'b0, 20, 1'b0, "R10");  // abandoned frame
      run_frame(1'b1, 4'd1, 1'b0, 75, 1'b1, "R10");  // clean after abandon

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule